// File: doc/BRIEF.md
# LCD Panel Timing Generator

This block drives the raster timing of a TFT LCD panel from three packed 32-bit timing words. Every pixel clock it advances a horizontal position counter, and at the end of each line it advances a vertical line counter. From these two counters it produces the horizontal and vertical sync pulses, the data-enable window, the column and row of the pixel being shown, and a one-clock start-of-frame strobe.

The horizontal layout comes from `tim0` and the vertical layout from `tim1`. Most fields are stored as the value minus one. The vertical porches are the exception: they are stored as the plain line count, so zero is allowed. Two bits of `tim2` choose the sync polarities. When `dual` is set, the panel is split into an upper and a lower half that are scanned together, and the programmed line count covers one half. In that mode the block also reports the row being driven on the lower half.

The words are taken on the first clock of each frame and held for the rest of that frame. Software can therefore rewrite them at any time, and the new values take effect cleanly from the next frame.

Top module: `lcd_tgen`

## Requirements
- R1: Each line runs in this order:
  - sync: `tim0[15:8]`+1 clocks;
  - back porch: `tim0[31:24]`+1 clocks;
  - active pixels: (`tim0[7:2]`+1)×16 clocks, anywhere from 16 to 1024;
  - front porch: `tim0[23:16]`+1 clocks.

  The line length is the sum of the four. `hsync` is at its active level only during the sync part.
- R2: Each frame runs in this order:
  - sync: `tim1[15:10]`+1 lines;
  - back porch: `tim1[31:24]` lines;
  - active: `tim1[9:0]`+1 lines;
  - front porch: `tim1[23:16]` lines.

  A porch value of zero gives no porch lines. `vsync` is active for the whole of each sync line and changes level only on the first clock of a line.
- R3: `de` is high only when the clock lies in both the active column range and the active line range. One frame therefore holds exactly active-pixels × active-lines cycles of `de`, and `de` is never high during either sync.
- R4: While `de` is high, `pix_x` counts 0, 1, 2 … across each active line, and `line_y` gives the active line index starting at 0. Both read 0 whenever `de` is low.
- R5: Sync polarity is set by `tim2`:
  - `tim2` bit 12 set makes `hsync` active low;
  - `tim2` bit 11 set makes `vsync` active low;
  - with a bit clear, that sync is active high;
  - the other bits of `tim2` have no effect.
- R6: `sof` is high for exactly one clock per frame: the first clock of the frame, which is also the first clock of both syncs. Successive pulses are one full frame length apart.
- R7: The values of `tim0`, `tim1`, `tim2` and `dual` seen on a frame's first clock govern that whole frame. A change made later in the frame first takes effect on the next frame.
- R8: While `en` is low:
  - both counters are held at zero;
  - `de`, `sof`, `pix_x`, `line_y` and `line_y_lo` are 0;
  - each sync sits at its inactive level.

  The clock on which `en` is first seen high is the first clock of a new frame.
- R9: With `dual` high, `line_y_lo` equals `line_y` plus the programmed active line count while `de` is high, which is the row on the lower half. It is 0 when `de` is low or `dual` is low. `dual` does not change the line or frame lengths.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; low holds the raster idle |
| dual | input | 1 | Split-panel mode; programmed line count is one half |
| tim0 | input | 32 | Horizontal timing word |
| tim1 | input | 32 | Vertical timing word |
| tim2 | input | 32 | Polarity word (bits 12 and 11 used) |
| hsync | output | 1 | Horizontal sync, polarity per `tim2[12]` |
| vsync | output | 1 | Vertical sync, polarity per `tim2[11]` |
| de | output | 1 | Data enable, high on visible pixels |
| pix_x | output | CNT_W | Active column, 0 outside `de` |
| line_y | output | CNT_W | Active row, 0 outside `de` |
| line_y_lo | output | CNT_W | Lower-half row in split-panel mode |
| sof | output | 1 | One-clock start-of-frame strobe |

## Verification
The assertions rely on the field encodings: every sync length is at least one clock or line, and every line and frame total fits in the counter width. Under those conditions `de` can never run on from one line into the next, and a sync can never be empty. The assertions also assume that whatever the timing inputs do in mid-frame, the shadow copy keeps the frame's geometry fixed. For this reason the stimulus is allowed to rewrite a word in the middle of a frame. The stimulus keeps all field values inside their encoded ranges, and it exercises the widest line (1024 pixels) together with zero vertical porches.

// File: rtl/lcd_tgen_pkg.sv
`timescale 1ns/1ps
package lcd_tgen_pkg;

  localparam int LEN_W = 11;          // widest single span: 1024 active pixels or lines

  // horizontal word fields
  localparam int HUNIT_LSB = 2;
  localparam int HUNIT_W   = 6;
  localparam int PIX_UNIT_LOG2 = 4;   // active width counted in groups of 16
  localparam int HSW_LSB   = 8;
  localparam int HFP_LSB   = 16;
  localparam int HBP_LSB   = 24;
  localparam int HFLD_W    = 8;

  // vertical word fields
  localparam int VACT_LSB  = 0;
  localparam int VACT_W    = 10;
  localparam int VSW_LSB   = 10;
  localparam int VSW_W     = 6;
  localparam int VFP_LSB   = 16;
  localparam int VBP_LSB   = 24;
  localparam int VFLD_W    = 8;

  // polarity word bits
  localparam int HS_INV_BIT = 12;
  localparam int VS_INV_BIT = 11;

  typedef struct packed {
    logic [LEN_W-1:0] hsw;
    logic [LEN_W-1:0] hbp;
    logic [LEN_W-1:0] hact;
    logic [LEN_W-1:0] hfp;
    logic [LEN_W-1:0] vsw;
    logic [LEN_W-1:0] vbp;
    logic [LEN_W-1:0] vact;
    logic [LEN_W-1:0] vfp;
    logic             hs_low;
    logic             vs_low;
    logic             dual;
  } cfg_t;

  // stored-minus-one field to a length
  function automatic logic [LEN_W-1:0] from_m1(input logic [LEN_W-1:0] f);
    return f + LEN_W'(1);
  endfunction

  // sum of the four parts of a line or a frame
  function automatic logic [LEN_W+1:0] span_total(
    input logic [LEN_W-1:0] s, input logic [LEN_W-1:0] b,
    input logic [LEN_W-1:0] a, input logic [LEN_W-1:0] f);
    return (LEN_W+2)'(s) + (LEN_W+2)'(b) + (LEN_W+2)'(a) + (LEN_W+2)'(f);
  endfunction

  function automatic cfg_t decode_words(
    input logic [31:2] t0, input logic [31:0] t1,
    input logic hs_inv, input logic vs_inv, input logic dual_mode);
    cfg_t c;
    c.hact   = from_m1(LEN_W'(t0[HUNIT_LSB +: HUNIT_W])) << PIX_UNIT_LOG2;
    c.hsw    = from_m1(LEN_W'(t0[HSW_LSB +: HFLD_W]));
    c.hfp    = from_m1(LEN_W'(t0[HFP_LSB +: HFLD_W]));
    c.hbp    = from_m1(LEN_W'(t0[HBP_LSB +: HFLD_W]));
    c.vact   = from_m1(LEN_W'(t1[VACT_LSB +: VACT_W]));
    c.vsw    = from_m1(LEN_W'(t1[VSW_LSB +: VSW_W]));
    c.vfp    = LEN_W'(t1[VFP_LSB +: VFLD_W]);
    c.vbp    = LEN_W'(t1[VBP_LSB +: VFLD_W]);
    c.hs_low = hs_inv;
    c.vs_low = vs_inv;
    c.dual   = dual_mode;
    return c;
  endfunction

endpackage

// File: rtl/lcd_tgen_shadow.sv
`timescale 1ns/1ps
module lcd_tgen_shadow (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  lcd_tgen_pkg::cfg_t   cfg_in,
  output lcd_tgen_pkg::cfg_t   cfg_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_q <= '0;
    else if (load) cfg_q <= cfg_in;
  end

endmodule

// File: rtl/lcd_tgen_axis.sv
`timescale 1ns/1ps
module lcd_tgen_axis #(
  parameter int CNT_W = 11,
  parameter int LEN_W = lcd_tgen_pkg::LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             adv,
  input  logic [LEN_W-1:0] sync_len,
  input  logic [LEN_W-1:0] bp_len,
  input  logic [LEN_W-1:0] act_len,
  input  logic [LEN_W-1:0] fp_len,
  output logic [CNT_W-1:0] pos_q,
  output logic             last,
  output logic             sync_zone,
  output logic             act_zone,
  output logic [CNT_W-1:0] act_idx
);

  localparam int TW = LEN_W + 2;

  logic [TW-1:0] pos_w, total, act_lo, act_hi;

  assign pos_w     = TW'(pos_q);
  assign total     = lcd_tgen_pkg::span_total(sync_len, bp_len, act_len, fp_len);
  assign act_lo    = TW'(sync_len) + TW'(bp_len);
  assign act_hi    = act_lo + TW'(act_len);
  assign last      = (pos_w == total - TW'(1));
  assign sync_zone = (pos_w < TW'(sync_len));
  assign act_zone  = (pos_w >= act_lo) && (pos_w < act_hi);
  assign act_idx   = CNT_W'(pos_w - act_lo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pos_q <= '0;
    else if (!run) pos_q <= '0;
    else if (adv)  pos_q <= last ? '0 : pos_q + CNT_W'(1);
  end

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pos_q == '0)); // R8

  AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (pos_w < total)); // R1

endmodule

// File: rtl/lcd_tgen.sv
`timescale 1ns/1ps
module lcd_tgen #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             dual,
  input  logic [31:0]      tim0,
  input  logic [31:0]      tim1,
  input  logic [31:0]      tim2,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic [CNT_W-1:0] pix_x,
  output logic [CNT_W-1:0] line_y,
  output logic [CNT_W-1:0] line_y_lo,
  output logic             sof
);

  import lcd_tgen_pkg::*;

  cfg_t live_cfg, held_cfg, cfg;

  logic [CNT_W-1:0] h_pos, v_pos, h_idx, v_idx;
  logic h_last, h_sync_zone, h_act_zone;
  logic v_last, v_sync_zone, v_act_zone;
  logic at_origin;

  // bits of the words that carry no TFT timing
  logic word_bits_unused;
  assign word_bits_unused = ^{tim0[1:0], tim2[31:13], tim2[10:0]};

  assign live_cfg  = decode_words(tim0[31:2], tim1, tim2[HS_INV_BIT],
                                  tim2[VS_INV_BIT], dual);
  assign at_origin = (h_pos == '0) && (v_pos == '0);
  // first clock of a frame uses the words as presented; the rest of the
  // frame uses the copy taken on that clock
  assign cfg       = at_origin ? live_cfg : held_cfg;

  lcd_tgen_shadow u_shadow (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (at_origin),
    .cfg_in (live_cfg),
    .cfg_q  (held_cfg)
  );

  lcd_tgen_axis #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_hax (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (en),
    .adv       (1'b1),
    .sync_len  (cfg.hsw),
    .bp_len    (cfg.hbp),
    .act_len   (cfg.hact),
    .fp_len    (cfg.hfp),
    .pos_q     (h_pos),
    .last      (h_last),
    .sync_zone (h_sync_zone),
    .act_zone  (h_act_zone),
    .act_idx   (h_idx)
  );

  lcd_tgen_axis #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_vax (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (en),
    .adv       (h_last),
    .sync_len  (cfg.vsw),
    .bp_len    (cfg.vbp),
    .act_len   (cfg.vact),
    .fp_len    (cfg.vfp),
    .pos_q     (v_pos),
    .last      (v_last),
    .sync_zone (v_sync_zone),
    .act_zone  (v_act_zone),
    .act_idx   (v_idx)
  );

  logic frame_end;
  assign frame_end = h_last && v_last;

  assign de        = en && h_act_zone && v_act_zone;
  assign hsync     = (en && h_sync_zone) ^ cfg.hs_low;
  assign vsync     = (en && v_sync_zone) ^ cfg.vs_low;
  assign sof       = en && at_origin;
  assign pix_x     = de ? h_idx : '0;
  assign line_y    = de ? v_idx : '0;
  assign line_y_lo = (de && cfg.dual) ? v_idx + CNT_W'(cfg.vact) : '0;

  AST_SOF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> !sof); // R6

  AST_SOF_AFTER_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
    (en && frame_end) |=> (sof || !en)); // R6

  AST_DE_OUTSIDE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (!h_sync_zone && !v_sync_zone)); // R3

  AST_X_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (de && $past(de)) |-> (pix_x == CNT_W'($past(pix_x) + CNT_W'(1)))); // R4

  AST_VSYNC_LINE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(v_sync_zone) |-> (h_pos == '0)); // R2

endmodule

// File: tb/lcd_tgen_test.sv
`timescale 1ns/1ps
module lcd_tgen_test;

  localparam int CNT_W = 11;

  typedef struct packed {
    logic [31:0] t0;
    logic [31:0] t1;
    logic [31:0] t2;
    logic        dl;
    int          frame;
    int          dec;
    int          hsc;
    int          vsc;
    int          vact;
  } vec_t;

  // words, split flag, frame clocks, de clocks, hsync clocks, vsync clocks, active lines
  localparam vec_t VECS [5] = '{
    '{32'h0000_0000, 32'h0000_0001, 32'h0000_0000, 1'b0,   57,   32,  3,   19, 2},
    '{32'h0301_0204, 32'h0201_0402, 32'h0000_1800, 1'b1,  328,   96, 24,   82, 3},
    '{32'h0002_0100, 32'h0102_0003, 32'h0000_1000, 1'b0,  176,   64, 16,   22, 4},
    '{32'h0100_0000, 32'h0000_0800, 32'h03FF_0800, 1'b1,   80,   16,  4,   60, 1},
    '{32'h0000_00FC, 32'h0000_0000, 32'h0000_0000, 1'b0, 2054, 1024,  2, 1027, 1}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, en, dual;
  logic [31:0] tim0, tim1, tim2;
  logic hsync, vsync, de, sof;
  logic [CNT_W-1:0] pix_x, line_y, line_y_lo;

  int checks = 0;
  int fails  = 0;

  lcd_tgen #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .dual(dual),
    .tim0(tim0), .tim1(tim1), .tim2(tim2),
    .hsync(hsync), .vsync(vsync), .de(de),
    .pix_x(pix_x), .line_y(line_y), .line_y_lo(line_y_lo), .sof(sof)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // steps to the next sof; len = clocks from the current one
  task automatic next_sof(output int len);
    len = 0;
    do begin
      @(negedge clk); #1;
      len++;
    end while (!sof && len < 5000);
  endtask

  // samples one whole frame that starts on the current clock
  task automatic run_frame(input vec_t v, input int idx);
    int extra_sof = 0, hs_n = 0, vs_n = 0, de_n = 0, xy_bad = 0, lo_bad = 0;
    int xexp = 0, yexp = 0, lo_exp;
    bit prev_de = 0;
    #1;
    chk("R6", $sformatf("vec%0d sof on first clock", idx), sof, 1);
    for (int c = 0; c < v.frame; c++) begin
      if (c != 0 && sof) extra_sof++;
      if (hsync != v.t2[12]) hs_n++;
      if (vsync != v.t2[11]) vs_n++;
      if (de) begin
        de_n++;
        if (pix_x != xexp || line_y != yexp) xy_bad++;
        lo_exp = v.dl ? yexp + v.vact : 0;
        if (line_y_lo != lo_exp) lo_bad++;
        xexp++;
      end else begin
        if (prev_de) begin yexp++; xexp = 0; end
        if (pix_x != 0 || line_y != 0 || line_y_lo != 0) xy_bad++;
      end
      prev_de = de;
      @(negedge clk); #1;
    end
    chk("R2", $sformatf("vec%0d sof one frame later", idx), sof, 1);
    chk("R6", $sformatf("vec%0d extra sof pulses", idx), extra_sof, 0);
    chk("R3", $sformatf("vec%0d de clocks", idx), de_n, v.dec);
    chk("R1", $sformatf("vec%0d hsync active clocks (R5 polarity)", idx), hs_n, v.hsc);
    chk("R2", $sformatf("vec%0d vsync active clocks (R5 polarity)", idx), vs_n, v.vsc);
    chk("R4", $sformatf("vec%0d x/y mismatches", idx), xy_bad, 0);
    chk("R9", $sformatf("vec%0d lower-half row mismatches", idx), lo_bad, 0);
  endtask

  task automatic start_cfg(input vec_t v);
    @(negedge clk);
    en = 1'b0; tim0 = v.t0; tim1 = v.t1; tim2 = v.t2; dual = v.dl;
    @(negedge clk);
    en = 1'b1;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int l1, l2;
    rst_n = 1'b0; en = 1'b0; dual = 1'b0;
    tim0 = '0; tim1 = '0; tim2 = '0;
    repeat (3) @(negedge clk);
    #1;
    // reset state, R8
    chk("R8", "reset hsync", hsync, 0);
    chk("R8", "reset vsync", vsync, 0);
    chk("R8", "reset de", de, 0);
    chk("R8", "reset sof", sof, 0);
    chk("R8", "reset pix_x", pix_x, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // inactive levels follow polarity while disabled, R5 R8
    @(negedge clk);
    tim2 = 32'h0000_1800;
    #1;
    chk("R5", "idle hsync with low polarity", hsync, 1);
    chk("R5", "idle vsync with low polarity", vsync, 1);
    chk("R8", "idle line_y_lo", line_y_lo, 0);

    // table walk
    for (int i = 0; i < 5; i++) begin
      start_cfg(VECS[i]);
      run_frame(VECS[i], i);
    end

    // mid-frame rewrite, R7
    start_cfg(VECS[0]);
    repeat (10) @(negedge clk);
    tim0 = VECS[2].t0;
    next_sof(l1);
    chk("R7", "frame length with mid-frame write", 10 + l1, 57);
    next_sof(l2);
    chk("R7", "next frame uses new line word", l2, 66);

    // enable drop in mid-frame and restart, R8
    start_cfg(VECS[1]);
    repeat (30) @(negedge clk);
    en = 1'b0;
    #1;
    chk("R8", "drop hsync inactive", hsync, 1);
    chk("R8", "drop vsync inactive", vsync, 1);
    chk("R8", "drop de", de, 0);
    chk("R8", "drop sof", sof, 0);
    repeat (5) @(negedge clk);
    en = 1'b1;
    #1;
    chk("R8", "restart sof at once", sof, 1);
    next_sof(l1);
    chk("R8", "restart gives full frame", l1, 328);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule